// File: doc/BRIEF.md
# PHY Mode Configuration Sequencer

This block programs the pad and delay-line PHY of a storage-card host. The PHY sits behind a byte-wide register port. Right after reset the block runs a fixed power-up routine on its own. That routine switches on the pad drivers and calibration, waits for pad calibration to finish, enables receivers, pull-ups and lane power on the command, data, strobe and clock lanes, and then selects the legacy timing code.

After that, each `start` pulse carries a bus timing mode, output and input tap values, a drive strength, a delay-line trim and the new card clock in kHz. The block sends a mode-dependent series of writes and read-modify-writes to the PHY. For the faster modes it also restarts the delay line and waits for it to lock. If the clock equals the one last requested, nothing is sent. Every wait has a cycle budget. A wait that runs past it ends the sequence, and `err` is raised together with `done`.

Top module: `phycfg_seq`

## Requirements
- R1: After reset the block runs the power-up routine without a request. It sets bits 0x42 in register 0x01 and bit 0x02 in 0x02, each by read-modify-write. It then reads 0x03 until bit 4 is set. Next it ORs 0x03 into 0x06, 0x02 into 0x08, 0x01 into 0x20, 0xFF into 0x07, 0xFF into 0x09, 0xFF into 0x21, 0x01 into 0x22, 0x01 into 0x23 and 0x07 into 0x0F, in that order. Finally it writes 0x04 to 0x11 and pulses `done` with `err` low.
- R2: The `mode` input is coded as 0 legacy, 1 high-speed, 2 HS200, 3 DDR50, 4 HS400 and 5 enhanced strobe. The first write of a mode sequence goes to register 0x11. It carries 0x04 for legacy, 0x08 for DDR50, 0x02 for HS400 and 0x01 for enhanced strobe. It carries 0x00 for high-speed and HS200.
- R3: In HS400 and HS200 only, the second access reads register 0x01 and writes back the value read ORed with `drv` shifted left by 2.
- R4: Register 0x0D is written next and then register 0x0C. In legacy mode both get 0. In every other mode 0x0D gets (`otap`<<1)|1. Register 0x0C gets (`itap`<<1)|1, except in HS200, where it gets 0.
- R5: In non-legacy modes the sequence continues with these steps, in order: write `trim` to 0x12, write 0 to 0x00, write (fsel<<5)|0x08 to 0x00, then read 0x00 until bit 4 is set. In legacy mode the sequence ends after writing 0 to 0x00.
- R6: fsel is 0 for 200000 kHz, 2 for 100000 kHz and 1 for 50000 kHz. Any other clock gives 0.
- R7: The clock of each accepted request is recorded, and 0 is recorded at reset. A request whose clock equals the recorded one causes no PHY access. Its `done` pulse comes one cycle after `start`, with `err` low and `busy` never raised.
- R8: A step whose access gets no acknowledge, or whose poll does not see its bit, within CLK_MHZ*POLL_US cycles ends the sequence. No later access is made. `done` and `err` are then pulsed together.
- R9: `start` is ignored while a sequence or the power-up routine runs. The ignored request changes neither the traffic nor the recorded clock.
- R10: `done` lasts one cycle. `err` is never high without `done`. `busy` is high from the cycle after an accepted, non-skipped `start` until `done`.
- R11: Mode codes 6 and 7 record the clock and finish with `done` but make no PHY access.
- R12: `phy_req` stays high with a stable direction, address and write data until `phy_ack`, or until the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| mode | input | 3 | Requested timing mode (R2 coding) |
| otap | input | TAP_W | Output tap value |
| itap | input | TAP_W | Input tap value |
| drv | input | DRV_W | Pad drive strength |
| trim | input | 8 | Delay-line trim value |
| freq_khz | input | FREQ_W | Requested card clock in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| phy_req | output | 1 | PHY access request, held until acknowledge |
| phy_wr | output | 1 | 1 write, 0 read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | PHY write data |
| phy_ack | input | 1 | One-cycle access acknowledge |
| phy_rdata | input | 8 | Read data, valid with phy_ack |

## Verification
The assertions assume that the PHY raises `phy_ack` only while `phy_req` is high, for one cycle per access, with read data valid in that cycle. They also assume that `start` is a single-cycle pulse. The bench PHY model responds only at the falling edge. It acks a pending request after a random delay of zero to three cycles and leaves `phy_ack` low once the request has dropped. Its calibration and lock bits clear for a set number of reads and can be held clear forever, or acks can be withheld, to drive the timeout paths.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

  typedef enum logic [2:0] {
    MD_LEGACY = 3'd0,
    MD_HS     = 3'd1,
    MD_HS200  = 3'd2,
    MD_DDR    = 3'd3,
    MD_HS400  = 3'd4,
    MD_ESTRB  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {K_WR, K_RMW, K_POLL} kind_e;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic       en;
    logic       last;
    kind_e      kind;
    logic [7:0] addr;
    logic [7:0] val;
  } step_t;

  localparam logic [7:0] R_DLL    = 8'h00;
  localparam logic [7:0] R_PAD_A  = 8'h01;
  localparam logic [7:0] R_PAD_B  = 8'h02;
  localparam logic [7:0] R_PAD_ST = 8'h03;
  localparam logic [7:0] R_RXEN_A = 8'h06;
  localparam logic [7:0] R_RXEN_B = 8'h07;
  localparam logic [7:0] R_PULL_A = 8'h08;
  localparam logic [7:0] R_PULL_B = 8'h09;
  localparam logic [7:0] R_RXTAP  = 8'h0C;
  localparam logic [7:0] R_TXTAP  = 8'h0D;
  localparam logic [7:0] R_CKBUF  = 8'h0F;
  localparam logic [7:0] R_MODE   = 8'h11;
  localparam logic [7:0] R_TRIM   = 8'h12;
  localparam logic [7:0] R_LN_CMD = 8'h20;
  localparam logic [7:0] R_LN_DAT = 8'h21;
  localparam logic [7:0] R_LN_STB = 8'h22;
  localparam logic [7:0] R_LN_CLK = 8'h23;

  localparam logic [7:0] LOCK_BIT = 8'h10;

  function automatic step_t mk(logic en, logic last, kind_e k,
                               logic [7:0] a, logic [7:0] v);
    step_t s;
    s.en = en; s.last = last; s.kind = k; s.addr = a; s.val = v;
    return s;
  endfunction

  function automatic logic [7:0] mode_code(mode_e m);
    case (m)
      MD_ESTRB:  return 8'h01;
      MD_HS400:  return 8'h02;
      MD_LEGACY: return 8'h04;
      MD_DDR:    return 8'h08;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] freq_sel(logic [31:0] khz);
    case (khz)
      32'd200000: return 2'd0;
      32'd100000: return 2'd2;
      32'd50000:  return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/phycfg_timer.sv
module phycfg_timer #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/phycfg_steps.sv
module phycfg_steps import phycfg_pkg::*; #(
  parameter int TAP_W = 4,
  parameter int DRV_W = 2
) (
  input  logic             init_ph,
  input  logic [IDX_W-1:0] idx,
  input  mode_e            mode,
  input  logic [TAP_W-1:0] otap,
  input  logic [TAP_W-1:0] itap,
  input  logic [DRV_W-1:0] drv,
  input  logic [7:0]       trim,
  input  logic [1:0]       fsel,
  output step_t            step
);
  logic legacy, pad_drv, no_rx_tap;
  logic [7:0] tx_val, rx_val;

  assign legacy    = (mode == MD_LEGACY);
  assign pad_drv   = (mode == MD_HS400) || (mode == MD_HS200);
  assign no_rx_tap = legacy || (mode == MD_HS200);
  assign tx_val    = legacy ? 8'h00 : 8'({otap, 1'b1});
  assign rx_val    = no_rx_tap ? 8'h00 : 8'({itap, 1'b1});

  always_comb begin
    step = mk(1'b0, 1'b1, K_WR, 8'h00, 8'h00);
    if (init_ph) begin
      case (idx)
        4'd0:  step = mk(1'b1, 1'b0, K_RMW,  R_PAD_A,  8'h42);
        4'd1:  step = mk(1'b1, 1'b0, K_RMW,  R_PAD_B,  8'h02);
        4'd2:  step = mk(1'b1, 1'b0, K_POLL, R_PAD_ST, LOCK_BIT);
        4'd3:  step = mk(1'b1, 1'b0, K_RMW,  R_RXEN_A, 8'h03);
        4'd4:  step = mk(1'b1, 1'b0, K_RMW,  R_PULL_A, 8'h02);
        4'd5:  step = mk(1'b1, 1'b0, K_RMW,  R_LN_CMD, 8'h01);
        4'd6:  step = mk(1'b1, 1'b0, K_RMW,  R_RXEN_B, 8'hFF);
        4'd7:  step = mk(1'b1, 1'b0, K_RMW,  R_PULL_B, 8'hFF);
        4'd8:  step = mk(1'b1, 1'b0, K_RMW,  R_LN_DAT, 8'hFF);
        4'd9:  step = mk(1'b1, 1'b0, K_RMW,  R_LN_STB, 8'h01);
        4'd10: step = mk(1'b1, 1'b0, K_RMW,  R_LN_CLK, 8'h01);
        4'd11: step = mk(1'b1, 1'b0, K_RMW,  R_CKBUF,  8'h07);
        4'd12: step = mk(1'b1, 1'b1, K_WR,   R_MODE,   mode_code(MD_LEGACY));
        default: step = mk(1'b0, 1'b1, K_WR, 8'h00, 8'h00);
      endcase
    end else begin
      case (idx)
        4'd0: step = mk(1'b1,    1'b0, K_WR,  R_MODE,  mode_code(mode));
        4'd1: step = mk(pad_drv, 1'b0, K_RMW, R_PAD_A, 8'({drv, 2'b00}));
        4'd2: step = mk(1'b1,    1'b0, K_WR,  R_TXTAP, tx_val);
        4'd3: step = mk(1'b1,    1'b0, K_WR,  R_RXTAP, rx_val);
        4'd4: step = mk(!legacy, 1'b0, K_WR,  R_TRIM,  trim);
        4'd5: step = mk(1'b1,    1'b0, K_WR,  R_DLL,   8'h00);
        4'd6: step = mk(!legacy, 1'b0, K_WR,  R_DLL,   {1'b0, fsel, 5'b01000});
        4'd7: step = mk(!legacy, 1'b1, K_POLL, R_DLL,  LOCK_BIT);
        default: step = mk(1'b0, 1'b1, K_WR, 8'h00, 8'h00);
      endcase
    end
  end

endmodule

// File: rtl/phycfg_xfer.sv
module phycfg_xfer import phycfg_pkg::*; #(
  parameter int LIMIT = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  step_t      step_i,
  input  logic       ack,
  input  logic [7:0] rdata,
  output logic       req,
  output logic       wr,
  output logic [7:0] addr,
  output logic [7:0] wdata,
  output logic       fin,
  output logic       fail
);
  typedef enum logic [1:0] {X_IDLE, X_RD, X_GAP, X_WR} xstate_e;

  xstate_e    st;
  kind_e      kind_q;
  logic [7:0] val_q;
  logic       gap_wr;
  logic       expired, hit, active;

  assign active = (st == X_RD) || (st == X_WR);
  assign hit    = (rdata & val_q) != 8'h00;

  phycfg_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(go), .run(st != X_IDLE), .expired(expired)
  );

  assign fin  = ack && ((st == X_WR) || (st == X_RD && kind_q == K_POLL && hit));
  assign fail = (active && !ack && expired) ||
                (st == X_RD && ack && kind_q == K_POLL && !hit && expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= X_IDLE;
      req    <= 1'b0;
      wr     <= 1'b0;
      addr   <= 8'h00;
      wdata  <= 8'h00;
      kind_q <= K_WR;
      val_q  <= 8'h00;
      gap_wr <= 1'b0;
    end else begin
      case (st)
        X_IDLE: if (go) begin
          kind_q <= step_i.kind;
          val_q  <= step_i.val;
          addr   <= step_i.addr;
          req    <= 1'b1;
          if (step_i.kind == K_WR) begin
            wr    <= 1'b1;
            wdata <= step_i.val;
            st    <= X_WR;
          end else begin
            wr    <= 1'b0;
            wdata <= 8'h00;
            st    <= X_RD;
          end
        end
        X_RD: begin
          if (ack) begin
            req <= 1'b0;
            if (kind_q == K_RMW) begin
              wdata  <= rdata | val_q;
              gap_wr <= 1'b1;
              st     <= X_GAP;
            end else if (hit || expired) begin
              st <= X_IDLE;
            end else begin
              gap_wr <= 1'b0;
              st     <= X_GAP;
            end
          end else if (expired) begin
            req <= 1'b0;
            st  <= X_IDLE;
          end
        end
        X_GAP: begin
          req <= 1'b1;
          wr  <= gap_wr;
          st  <= gap_wr ? X_WR : X_RD;
        end
        X_WR: begin
          if (ack || expired) begin
            req <= 1'b0;
            st  <= X_IDLE;
          end
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !expired) |=> (req && $stable(wr) && $stable(addr) && $stable(wdata)));

  // R8
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && expired) |=> !req);

endmodule

// File: rtl/phycfg_seq.sv
module phycfg_seq import phycfg_pkg::*; #(
  parameter int CLK_MHZ = 200,
  parameter int POLL_US = 100,
  parameter int FREQ_W  = 20,
  parameter int TAP_W   = 4,
  parameter int DRV_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [TAP_W-1:0]  otap,
  input  logic [TAP_W-1:0]  itap,
  input  logic [DRV_W-1:0]  drv,
  input  logic [7:0]        trim,
  input  logic [FREQ_W-1:0] freq_khz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              phy_req,
  output logic              phy_wr,
  output logic [7:0]        phy_addr,
  output logic [7:0]        phy_wdata,
  input  logic              phy_ack,
  input  logic [7:0]        phy_rdata
);
  localparam int LIMIT = CLK_MHZ * POLL_US;

  typedef enum logic [1:0] {T_BOOT, T_IDLE, T_ISSUE, T_WAIT} tstate_e;

  tstate_e           st;
  logic              init_ph;
  logic [IDX_W-1:0]  idx;
  mode_e             cap_mode;
  logic [TAP_W-1:0]  cap_otap, cap_itap;
  logic [DRV_W-1:0]  cap_drv;
  logic [7:0]        cap_trim;
  logic [1:0]        cap_fsel;
  logic [FREQ_W-1:0] last_freq;
  step_t             step;
  logic              go, fin, fail;

  assign go = (st == T_ISSUE) && step.en;

  phycfg_steps #(.TAP_W(TAP_W), .DRV_W(DRV_W)) u_steps (
    .init_ph(init_ph), .idx(idx), .mode(cap_mode), .otap(cap_otap),
    .itap(cap_itap), .drv(cap_drv), .trim(cap_trim), .fsel(cap_fsel),
    .step(step)
  );

  phycfg_xfer #(.LIMIT(LIMIT)) u_xfer (
    .clk(clk), .rst(rst), .go(go), .step_i(step), .ack(phy_ack),
    .rdata(phy_rdata), .req(phy_req), .wr(phy_wr), .addr(phy_addr),
    .wdata(phy_wdata), .fin(fin), .fail(fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_BOOT;
      init_ph   <= 1'b1;
      idx       <= '0;
      cap_mode  <= MD_LEGACY;
      cap_otap  <= '0;
      cap_itap  <= '0;
      cap_drv   <= '0;
      cap_trim  <= '0;
      cap_fsel  <= '0;
      last_freq <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        T_BOOT: begin
          busy    <= 1'b1;
          init_ph <= 1'b1;
          idx     <= '0;
          st      <= T_ISSUE;
        end
        T_IDLE: if (start) begin
          last_freq <= freq_khz;
          cap_mode  <= mode_e'(mode);
          cap_otap  <= otap;
          cap_itap  <= itap;
          cap_drv   <= drv;
          cap_trim  <= trim;
          cap_fsel  <= freq_sel(32'(freq_khz));
          if (freq_khz == last_freq || mode > 3'd5) begin
            done <= 1'b1;
          end else begin
            busy    <= 1'b1;
            init_ph <= 1'b0;
            idx     <= '0;
            st      <= T_ISSUE;
          end
        end
        T_ISSUE: begin
          if (step.en) begin
            st <= T_WAIT;
          end else if (step.last) begin
            st   <= T_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        T_WAIT: begin
          if (fail) begin
            st   <= T_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
            err  <= 1'b1;
          end else if (fin) begin
            if (step.last) begin
              st   <= T_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= T_ISSUE;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(last_freq) && $stable(cap_mode) && $stable(cap_trim)));

  // R8
  no_access_after_err_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !phy_req);

endmodule

// File: tb/phycfg_seq_bench.sv
`timescale 1ns/100ps
module phycfg_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  otap = '0, itap = '0;
  logic [1:0]  drv = '0;
  logic [7:0]  trim = '0;
  logic [19:0] freq_khz = '0;
  logic        busy, done, err;
  logic        phy_req, phy_wr, phy_ack = 1'b0;
  logic [7:0]  phy_addr, phy_wdata, phy_rdata = 8'h00;

  always #2.5 clk = ~clk;

  phycfg_seq #(.POLL_US(2)) u_phycfg_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .otap(otap),
    .itap(itap), .drv(drv), .trim(trim), .freq_khz(freq_khz),
    .busy(busy), .done(done), .err(err), .phy_req(phy_req),
    .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] mem [256];
  logic [7:0] wa [64];
  logic [7:0] wd [64];
  int nlog = 0;
  logic [7:0] ea [32];
  logic [7:0] ed [32];
  int ne = 0;
  int lat = 0, cal_cnt = 3, dll_cnt = 0, dll_delay = 2;
  bit dll_stuck = 0, ack_en = 1;
  int done_cnt = 0, viol = 0;
  logic prev_req = 0;
  logic [7:0] prev_addr = 0;
  int lf = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // PHY model, acts at falling edges only
  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
    if (phy_req && prev_req && !phy_ack && phy_addr != prev_addr) viol++;
    prev_req  = phy_req;
    prev_addr = phy_addr;
    phy_ack = 1'b0;
    if (!phy_req) lat = $urandom % 4;
    else if (lat > 0) lat--;
    else if (ack_en && !(prev_req && phy_ack)) begin
      if (phy_wr) begin
        mem[phy_addr] = phy_wdata;
        if (nlog < 64) begin wa[nlog] = phy_addr; wd[nlog] = phy_wdata; nlog++; end
        if (phy_addr == 8'h00 && phy_wdata[3]) dll_cnt = dll_delay;
      end else if (phy_addr == 8'h03) begin
        phy_rdata = (cal_cnt == 0) ? (mem[3] | 8'h10) : (mem[3] & 8'hEF);
        if (cal_cnt > 0) cal_cnt--;
      end else if (phy_addr == 8'h00) begin
        phy_rdata = (!dll_stuck && dll_cnt == 0) ? (mem[0] | 8'h10) : (mem[0] & 8'hEF);
        if (dll_cnt > 0) dll_cnt--;
      end else begin
        phy_rdata = mem[phy_addr];
      end
      phy_ack = 1'b1;
      lat = $urandom % 4;
    end
  end

  task automatic add_exp(logic [7:0] a, logic [7:0] d);
    ea[ne] = a; ed[ne] = d; ne++;
  endtask

  function automatic logic [7:0] fs_of(int f);
    if (f == 200000) return 8'd0;
    if (f == 100000) return 8'd2;
    if (f == 50000)  return 8'd1;
    return 8'd0;
  endfunction

  task automatic build_init();
    ne = 0;
    add_exp(8'h01, mem[8'h01] | 8'h42);
    add_exp(8'h02, mem[8'h02] | 8'h02);
    add_exp(8'h06, mem[8'h06] | 8'h03);
    add_exp(8'h08, mem[8'h08] | 8'h02);
    add_exp(8'h20, mem[8'h20] | 8'h01);
    add_exp(8'h07, mem[8'h07] | 8'hFF);
    add_exp(8'h09, mem[8'h09] | 8'hFF);
    add_exp(8'h21, mem[8'h21] | 8'hFF);
    add_exp(8'h22, mem[8'h22] | 8'h01);
    add_exp(8'h23, mem[8'h23] | 8'h01);
    add_exp(8'h0F, mem[8'h0F] | 8'h07);
    add_exp(8'h11, 8'h04);
  endtask

  task automatic build_mode(int m, int ot, int it, int dv, int tr, int f);
    logic [7:0] code;
    bit leg;
    leg  = (m == 0);
    code = (m == 5) ? 8'h01 : (m == 4) ? 8'h02 : (m == 0) ? 8'h04 : (m == 3) ? 8'h08 : 8'h00;
    ne = 0;
    add_exp(8'h11, code);
    if (m == 4 || m == 2) add_exp(8'h01, mem[8'h01] | 8'(dv << 2));
    if (leg) begin
      add_exp(8'h0D, 8'h00);
      add_exp(8'h0C, 8'h00);
    end else begin
      add_exp(8'h0D, 8'((ot << 1) | 1));
      add_exp(8'h0C, (m == 2) ? 8'h00 : 8'((it << 1) | 1));
      add_exp(8'h12, 8'(tr));
    end
    add_exp(8'h00, 8'h00);
    if (!leg) add_exp(8'h00, 8'((fs_of(f) << 5) | 8'h08));
  endtask

  task automatic cmp_log(string rq);
    chk(nlog == ne, rq, "write count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++)
      chk(wa[i] == ea[i] && wd[i] == ed[i], rq, $sformatf("write %0d", i),
          {wa[i], wd[i]}, {ea[i], ed[i]});
  endtask

  task automatic wait_done(output bit seen);
    int c;
    c = 0;
    while (!done && c < 3000) begin @(negedge clk); c++; end
    seen = done;
  endtask

  // per-mode taps and trim
  task automatic tab(int m, output int ot, output int it, output int tr);
    ot = 0; it = 0; tr = 8;
    case (m)
      0: tr = 0;
      1: begin ot = 3; it = 2; end
      2: ot = 2;
      3: ot = 1;
      4: begin ot = 1; it = 10; end
      5: ot = 1;
      default: ;
    endcase
  endtask

  task automatic run(int m, int dv, int f, bit poke, bit dead, bit exp_err, string rq);
    int ot, it, tr, d0;
    bit skip, seen;
    tab(m, ot, it, tr);
    skip = (f == lf) || (m > 5);
    if (skip || dead) ne = 0; else build_mode(m, ot, it, dv, tr, f);
    lf = f;
    nlog = 0;
    d0 = done_cnt;
    @(negedge clk);
    mode = 3'(m); otap = 4'(ot); itap = 4'(it); drv = 2'(dv); trim = 8'(tr);
    freq_khz = 20'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (skip) begin
      chk(done == 1'b1 && busy == 1'b0, rq, "immediate done without busy", {busy, done}, 2'b01);
    end else begin
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      if (poke) begin
        mode = 3'd0; freq_khz = 20'd25000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    wait_done(seen);
    chk(seen, rq, "done seen", seen, 1);
    chk(err == exp_err, rq, "err with done", err, exp_err);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    cmp_log(rq);
    chk(done_cnt == d0 + 1, "R10", "done pulse count", done_cnt - d0, 1);
  endtask

  initial begin
    bit seen;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[0] = mem[0] & 8'hEF;
    mem[3] = mem[3] & 8'hEF;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R10", "reset outputs", {busy, done, err}, 0);
    chk(phy_req == 0, "R12", "no request in reset", phy_req, 0);
    build_init();
    nlog = 0;
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1, "R1", "busy during power-up", busy, 1);
    wait_done(seen);
    chk(seen && !err, "R1", "power-up done without err", {seen, err}, 2'b10);
    chk(cal_cnt == 0, "R1", "calibration polled to ready", cal_cnt, 0);
    repeat (4) @(negedge clk);
    cmp_log("R1");

    run(0, 0, 25000,  0, 0, 0, "R4");
    run(1, 0, 50000,  0, 0, 0, "R6");
    run(2, 3, 100000, 0, 0, 0, "R3");
    run(3, 0, 200000, 0, 0, 0, "R5");
    run(4, 1, 50000,  0, 0, 0, "R2");
    run(5, 0, 100000, 0, 0, 0, "R2");
    run(5, 0, 100000, 0, 0, 0, "R7");
    run(4, 2, 100000, 0, 0, 0, "R7");
    run(6, 0, 33000,  0, 0, 0, "R11");
    run(1, 0, 33000,  0, 0, 0, "R11");
    run(2, 2, 200000, 1, 0, 0, "R9");
    run(0, 0, 200000, 0, 0, 0, "R9");

    dll_stuck = 1;
    run(3, 0, 50000, 0, 0, 1, "R8");
    dll_stuck = 0;
    ack_en = 0;
    run(1, 0, 100000, 0, 1, 1, "R8");
    ack_en = 1;

    for (int k = 0; k < 40; k++) begin
      int m, f, sel;
      m   = $urandom % 8;
      sel = $urandom % 4;
      f   = (sel == 0) ? 200000 : (sel == 1) ? 100000 : (sel == 2) ? 50000 : 40000;
      dll_delay = $urandom % 6;
      run(m, $urandom % 4, f, 0, 0, 0, "R5");
    end

    chk(viol == 0, "R12", "request held until ack", viol, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule